// File: doc/BRIEF.md
# Chip-Select and Termination Output-Enable Power-Down Timer

This block decides when the memory controller may stop driving the DRAM chip-select lines and the on-die-termination line while the DRAM sits in a low-power state. It watches the clock-enable vector. Once every clock-enable bit is low, it starts a countdown of a programmable number of DRAM clocks. When the countdown ends, it drops the output enable, so the pad tristates that output. The termination line has one extra condition: it can only be released while the controller reports self-refresh or a termination-off mode.

Each output has its own countdown channel and its own 4-bit delay input. A delay of zero keeps that output driven permanently. The delay is captured when a countdown begins, and the capture register resets to 6. An enable comes back combinationally in the same cycle that its qualifying condition goes away, so the pads are driven again before the DRAM leaves its low-power state.

Each channel is a three-state machine. ARMED means the output is enabled and no countdown is running. COUNTING means the output is enabled and the countdown is running. TRISTATED means the output enable is dropped. The transitions are:
- start: ARMED to COUNTING, when the condition holds and the delay is nonzero.
- abort: COUNTING to ARMED, when the condition drops.
- expire: COUNTING to TRISTATED, when the last count is reached while the condition still holds.
- wake: TRISTATED to ARMED, when the condition drops.

Top module: `pd_tristate_timer`

## Requirements
- R1: Out of reset, every bit of `cs_oe` and `odt_oe` is 1.
- R2: While `cs_delay` is 0 when a countdown would start, `cs_oe` stays all ones.
- R3: With `cs_delay` = D (1 to 15) captured in the first cycle that all `cke` bits are low, `cs_oe` drops to all zeros D clock edges after that cycle's edge, provided `cke` stays all low.
- R4: If any `cke` bit rises before a countdown completes, the countdown is abandoned and the output stays enabled. A later all-low period starts a full countdown again.
- R5: `cs_oe` returns to all ones combinationally, in the same cycle that any `cke` bit is high.
- R6: While `odt_delay` is 0 when a countdown would start, `odt_oe` stays 1.
- R7: `odt_oe` counts down, with the same timing as R3, only while all `cke` bits are low and `self_refresh` or `term_off` is 1. Outside that condition, `odt_oe` is never 0.
- R8: `odt_oe` returns to 1 in the same cycle that the mode condition drops or any `cke` bit rises.
- R9: A change to a delay input during a countdown does not alter that countdown. The new value applies from the next countdown.
- R10: All bits of `cs_oe` always carry the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DRAM clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | NUM_CKE | Clock-enable pin levels |
| self_refresh | input | 1 | DRAM is in self-refresh |
| term_off | input | 1 | Termination-off mode is active |
| cs_delay | input | DLY_W | Chip-select release delay in clocks; 0 means never release |
| odt_delay | input | DLY_W | Termination release delay in clocks; 0 means never release |
| cs_oe | output | NUM_CS | Chip-select output enables, all bits equal |
| odt_oe | output | 1 | Termination output enable |

## Verification
The embedded assertions check, on every cycle:
- a dropped condition always re-enables the output and sends the machine back to ARMED;
- TRISTATED is entered only from COUNTING;
- a zero delay never starts a countdown;
- the chip-select bits never disagree;
- the termination enable is never 0 outside low-power mode.

The exact expiry cycle for each delay, and the fact that a delay changed mid-count does not move the current expiry, are shown only by the bench. It does this by running its cycle-by-cycle reference model through countdowns of several lengths, aborts, mode flips and delay edits.

// File: rtl/pd_tristate_pkg.sv
package pd_tristate_pkg;

    typedef enum logic [1:0] {
        TMR_ARMED     = 2'd0,
        TMR_COUNTING  = 2'd1,
        TMR_TRISTATED = 2'd2
    } tmr_state_e;

    localparam int CH_CS  = 0;
    localparam int CH_ODT = 1;
    localparam int NUM_CH = 2;

endpackage

// File: rtl/pd_cond_qualifier.sv
module pd_cond_qualifier #(
    parameter int NUM_CKE = 4
) (
    input  logic [NUM_CKE-1:0] cke,
    input  logic               self_refresh,
    input  logic               term_off,
    output logic               cs_hold,
    output logic               odt_hold
);

    logic all_low;

    always_comb begin
        all_low  = ~|cke;
        cs_hold  = all_low;
        odt_hold = all_low & (self_refresh | term_off);
    end

endmodule

// File: rtl/pd_oe_countdown.sv
module pd_oe_countdown
    import pd_tristate_pkg::*;
#(
    parameter int DLY_W   = 4,
    parameter int DLY_RST = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [DLY_W-1:0] dly,
    output logic             oe_en
);

    localparam logic [DLY_W-1:0] LAST_CNT = DLY_W'(1);
    localparam logic [DLY_W-1:0] RST_CNT  = DLY_W'(DLY_RST);

    tmr_state_e       state_q, state_d;
    logic [DLY_W-1:0] cnt_q;
    logic             start_go;

    assign start_go = hold && (dly != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TMR_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TMR_ARMED: begin
                if (start_go) state_d = TMR_COUNTING;
            end
            TMR_COUNTING: begin
                if (!hold)                  state_d = TMR_ARMED;
                else if (cnt_q == LAST_CNT) state_d = TMR_TRISTATED;
            end
            TMR_TRISTATED: begin
                if (!hold) state_d = TMR_ARMED;
            end
            default: state_d = TMR_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= RST_CNT;
        end else if (state_q == TMR_ARMED && start_go) begin
            cnt_q <= dly;
        end else if (state_q == TMR_COUNTING && hold) begin
            cnt_q <= cnt_q - LAST_CNT;
        end
    end

    always_comb begin
        oe_en = (state_q != TMR_TRISTATED) || !hold;
    end

    // R4 / R8: a dropped condition always returns the machine to ARMED
    a_r4_abort_to_armed: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != TMR_ARMED && !hold) |=> state_q == TMR_ARMED);

    // R5 / R8: the output is enabled whenever the condition is absent
    a_r5_oe_without_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |-> oe_en);

    // R3: TRISTATED is reached only through COUNTING
    a_r3_via_counting: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TMR_TRISTATED && $past(state_q) != TMR_TRISTATED)
            |-> $past(state_q) == TMR_COUNTING);

    // R2 / R6: a zero delay never starts a countdown
    a_r2_zero_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TMR_ARMED && dly == '0) |=> state_q == TMR_ARMED);

endmodule

// File: rtl/pd_tristate_timer.sv
module pd_tristate_timer
    import pd_tristate_pkg::*;
#(
    parameter int NUM_CKE = 4,
    parameter int NUM_CS  = 10,
    parameter int DLY_W   = 4,
    parameter int DLY_RST = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CKE-1:0] cke,
    input  logic               self_refresh,
    input  logic               term_off,
    input  logic [DLY_W-1:0]   cs_delay,
    input  logic [DLY_W-1:0]   odt_delay,
    output logic [NUM_CS-1:0]  cs_oe,
    output logic               odt_oe
);

    logic [NUM_CH-1:0] ch_hold;
    logic [NUM_CH-1:0] ch_oe;
    logic [DLY_W-1:0]  ch_dly [NUM_CH];

    pd_cond_qualifier #(.NUM_CKE(NUM_CKE)) u_qual (
        .cke          (cke),
        .self_refresh (self_refresh),
        .term_off     (term_off),
        .cs_hold      (ch_hold[CH_CS]),
        .odt_hold     (ch_hold[CH_ODT])
    );

    assign ch_dly[CH_CS]  = cs_delay;
    assign ch_dly[CH_ODT] = odt_delay;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pd_oe_countdown #(.DLY_W(DLY_W), .DLY_RST(DLY_RST)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .hold  (ch_hold[g]),
            .dly   (ch_dly[g]),
            .oe_en (ch_oe[g])
        );
    end

    assign cs_oe  = {NUM_CS{ch_oe[CH_CS]}};
    assign odt_oe = ch_oe[CH_ODT];

    // R10: chip-select enables never disagree
    a_r10_cs_uniform: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_oe == '0) || (cs_oe == '1));

    // R7: termination released only in low-power mode with all clock enables low
    a_r7_odt_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
        !odt_oe |-> ((self_refresh || term_off) && cke == '0));

    // R5: any high clock enable means chip-selects are driven
    a_r5_cke_high_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (cke != '0) |-> (cs_oe == '1));

endmodule

// File: tb/pd_tristate_timer_tb.sv
module pd_tristate_timer_tb_top;

    localparam int NCKE = 4;
    localparam int NCS  = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NCKE-1:0] cke = '1;
    logic            self_refresh = 1'b0;
    logic            term_off = 1'b0;
    logic [3:0]      cs_delay = 4'd6;
    logic [3:0]      odt_delay = 4'd6;
    logic [NCS-1:0]  cs_oe;
    logic            odt_oe;

    int    n_vec = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    finished = 1'b0;

    always #10 clk = ~clk;

    pd_tristate_timer dut_i (
        .clk (clk), .rst_n (rst_n), .cke (cke),
        .self_refresh (self_refresh), .term_off (term_off),
        .cs_delay (cs_delay), .odt_delay (odt_delay),
        .cs_oe (cs_oe), .odt_oe (odt_oe)
    );

    // reference model: per channel, active flag, captured delay, run length
    bit m_act [2];
    int m_cap [2];
    int m_run [2];

    function automatic bit cond_of(int ch);
        bit low = (cke == '0);
        if (ch == 0) return low;
        return low && (self_refresh || term_off);
    endfunction

    function automatic int dly_of(int ch);
        return (ch == 0) ? int'(cs_delay) : int'(odt_delay);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_act[c] = 0; m_cap[c] = 6; m_run[c] = 0;
            end
        end else begin
            for (int c = 0; c < 2; c++) begin
                if (!cond_of(c)) begin
                    m_act[c] = 0; m_run[c] = 0;
                end else if (!m_act[c]) begin
                    if (dly_of(c) != 0) begin
                        m_act[c] = 1; m_cap[c] = dly_of(c); m_run[c] = 1;
                    end
                end else begin
                    m_run[c] = m_run[c] + 1;
                end
            end
        end
    end

    function automatic bit exp_oe(int c);
        return !(m_act[c] && m_run[c] > m_cap[c] && cond_of(c));
    endfunction

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [NCS-1:0] e_cs;
            e_cs = exp_oe(0) ? '1 : '0;
            n_vec++;
            if (cs_oe !== e_cs) begin
                n_bad++;
                $display("FAIL %s (R10 width) cs_oe actual=%b expected=%b t=%0t",
                         cur_req, cs_oe, e_cs, $time);
            end
            n_vec++;
            if (odt_oe !== exp_oe(1)) begin
                n_bad++;
                $display("FAIL %s odt_oe actual=%b expected=%b t=%0t",
                         cur_req, odt_oe, exp_oe(1), $time);
            end
        end
    end

    task automatic cyc(input logic [NCKE-1:0] k, input bit sr, input bit to,
                       input int n, input string req);
        cur_req = req;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            cke = k; self_refresh = sr; term_off = to;
        end
    endtask

    task automatic set_dly(input logic [3:0] c, input logic [3:0] o);
        @(posedge clk); #1;
        cs_delay = c; odt_delay = o;
    endtask

    initial begin
        #2000000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        #35;
        n_vec++;
        if (cs_oe !== '1 || odt_oe !== 1'b1) begin
            n_bad++;
            $display("FAIL R1 reset cs_oe=%b odt_oe=%b expected all ones", cs_oe, odt_oe);
        end
        @(negedge clk); rst_n = 1'b1;
        cyc(4'hF, 0, 0, 3, "R1");
        // R3: default delay 6 on CS; ODT stays on without mode (R7)
        cyc(4'h0, 0, 0, 10, "R3_R7");
        cyc(4'h2, 0, 0, 2, "R5");
        // R3 with several delays, plus ODT timing via self_refresh (R7)
        for (int d = 1; d <= 15; d += 3) begin
            set_dly(4'(d), 4'(16 - d));
            cyc(4'h0, 1, 0, 20, "R3_R7");
            cyc(4'h8, 1, 0, 2, "R5_R8");
        end
        // R4: abort before expiry, then full restart
        set_dly(4'd5, 4'd5);
        cyc(4'h0, 0, 1, 3, "R4");
        cyc(4'h1, 0, 1, 1, "R4");
        cyc(4'h0, 0, 1, 8, "R4");
        // R8: mode condition drops while tristated
        cyc(4'h0, 0, 0, 2, "R8");
        cyc(4'h0, 1, 0, 8, "R8");
        cyc(4'h4, 1, 0, 2, "R8");
        // R2 / R6: zero delay never releases
        set_dly(4'd0, 4'd0);
        cyc(4'h0, 1, 1, 20, "R2_R6");
        cyc(4'hF, 0, 0, 2, "R2_R6");
        // R9: delay change mid-countdown
        set_dly(4'd7, 4'd7);
        cyc(4'h0, 1, 0, 3, "R9");
        set_dly(4'd2, 4'd1);
        cyc(4'h0, 1, 0, 8, "R9");
        cyc(4'hF, 1, 0, 2, "R9");
        cyc(4'h0, 1, 0, 5, "R9");
        // R10: width checked on every compare above; mixed pattern run
        for (int i = 0; i < 40; i++)
            cyc(((i % 7) == 0) ? 4'h3 : 4'h0, (i % 5) < 3, (i % 11) == 0, 1, "R10");
        cyc(4'hF, 0, 0, 2, "R10");
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule